// File: doc/BRIEF.md
# Per-Bit Edge Detect Interrupt Controller

This block watches a parallel digital input port and records transitions on it. Two mask registers pick, bit by bit, which lines are watched for a low-to-high change and which for a high-to-low change. Any selected change sets one of two sticky flags, one for rising events and one for falling events. A single level-high interrupt line is raised when a flag is set, its event-type enable is on, and the master enable is on.

Software reaches the block through a small register port. It writes the two masks and a control word, reads all of them back, and reads a status word holding both flags and the interrupt level. A write-one strobe in the control word clears both flags and always reads back as 0. A mode bit selects how the port is sampled. After reset, or with the bit at 0, a direct low-latency path is used: each line is compared with its value one clock earlier. With the bit at 1, each line first passes a two-flop synchronizer, which is the safe choice for inputs that are truly asynchronous.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the rise mask (addr 0), fall mask (addr 1), control word (addr 2) and status word (addr 3) all read 0, so direct sampling mode is selected, and `irq_o` is 0.
- R2: A write to address 0 or address 1 stores the full data word as the rise mask or the fall mask, and a read of that address returns it.
- R3: A 0-to-1 change on an input bit whose rise-mask bit is 1 sets the rise flag (status bit 0). A change on a bit whose mask bit is 0 leaves the flag at 0.
- R4: A 1-to-0 change on an input bit whose fall-mask bit is 1 sets the fall flag (status bit 1). A change on a bit whose mask bit is 0 leaves the flag at 0.
- R5: Once a flag is set it stays set, whatever the inputs do, until a clear strobe arrives.
- R6: A write to address 2 with data bit 4 set clears both flags. Bits 3:0 of the written value are stored, and bit 4 always reads back as 0.
- R7: An enabled edge found in the same cycle as a clear strobe takes priority, and its flag stays set.
- R8: Control bits are: bit 0 master enable, bit 1 rise interrupt enable, bit 2 fall interrupt enable, bit 3 sampling mode (1 = synchronized). `irq_o` equals master AND ((rise flag AND rise enable) OR (fall flag AND fall enable)). Status bit 2 mirrors `irq_o`.
- R9: While the master enable is 0, `irq_o` stays 0 even when flags and event-type enables are set.
- R10: In direct mode a flag is set at the first clock edge after the input changes. In synchronized mode it is set at the third clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | Monitored input port |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
The bench aims an edge at the same clock as a clear strobe. A design that let the clear win would drop an interrupt and show a 0 flag. It pairs inverted masks with inverted transitions, so a design that swapped the rise and fall masks, or ignored masking, would set flags that must stay clear. It counts clocks in both sampling modes. A missing synchronizer stage, or one too many, moves the flag by one cycle. Finally it raises flags with the master enable off, and reads the control word back after a clear strobe, which catches a stored strobe bit or a master gate that is not applied.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADR_RISE_MASK = 2'd0;
   localparam logic [ADDR_W-1:0] ADR_FALL_MASK = 2'd1;
   localparam logic [ADDR_W-1:0] ADR_CTRL      = 2'd2;
   localparam logic [ADDR_W-1:0] ADR_STATUS    = 2'd3;

   localparam int CTRL_STORED_W = 4;
   localparam int CTRL_CLR_BIT  = 4;

   typedef struct packed {
      logic sync_mode;
      logic fall_ie;
      logic rise_ie;
      logic master_en;
   } ctrl_t;

endpackage

// File: rtl/edge_sampler.sv
module edge_sampler #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pins_i,
   input  logic             sync_mode,
   output logic [WIDTH-1:0] rise_vec,
   output logic [WIDTH-1:0] fall_vec
);

   localparam int LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("edge_sampler: SYNC_STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("edge_sampler: WIDTH must be at least 1");
      end
   endgenerate

   // direct path: raw pins against the previous raw sample
   logic [WIDTH-1:0] raw_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_prev_q <= '0;
      else        raw_prev_q <= pins_i;
   end

   // synchronized path: flop chain followed by a history stage
   logic [SYNC_STAGES-1:0][WIDTH-1:0] sync_q;
   logic [WIDTH-1:0]                  sync_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q      <= '0;
         sync_prev_q <= '0;
      end else begin
         sync_q      <= {sync_q[SYNC_STAGES-2:0], pins_i};
         sync_prev_q <= sync_q[LAST];
      end
   end

   logic [WIDTH-1:0] cur_s, old_s;

   always_comb begin
      if (sync_mode) begin
         cur_s = sync_q[LAST];
         old_s = sync_prev_q;
      end else begin
         cur_s = pins_i;
         old_s = raw_prev_q;
      end
      rise_vec =  cur_s & ~old_s;
      fall_vec = ~cur_s &  old_s;
   end

endmodule

// File: rtl/edge_flag.sv
module edge_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   output logic flag
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (flag_q & ~clr) | evt;
   end

   assign flag = flag_q;

   // R5
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

   // R7
   edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag);

   // R6
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> !flag);

endmodule

// File: rtl/edge_regs.sv
module edge_regs
   import edge_irq_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WIDTH-1:0]  wr_data,
   output logic [WIDTH-1:0]  rise_mask,
   output logic [WIDTH-1:0]  fall_mask,
   output ctrl_t             ctrl,
   output logic              clr_pulse
);

   generate
      if (WIDTH <= CTRL_CLR_BIT) begin : g_bad_width
         $error("edge_regs: WIDTH too small for the control word");
      end
   endgenerate

   logic [WIDTH-1:0] rise_mask_q, fall_mask_q;
   ctrl_t            ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_mask_q <= '0;
         fall_mask_q <= '0;
         ctrl_q      <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_RISE_MASK: rise_mask_q <= wr_data;
            ADR_FALL_MASK: fall_mask_q <= wr_data;
            ADR_CTRL:      ctrl_q      <= ctrl_t'(wr_data[CTRL_STORED_W-1:0]);
            default:       ;
         endcase
      end
   end

   assign clr_pulse = wr_en && (wr_addr == ADR_CTRL) && wr_data[CTRL_CLR_BIT];
   assign rise_mask = rise_mask_q;
   assign fall_mask = fall_mask_q;
   assign ctrl      = ctrl_q;

   // R2
   rise_mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_RISE_MASK) |=> (rise_mask == $past(wr_data)));

   // R2
   fall_mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_FALL_MASK) |=> (fall_mask == $past(wr_data)));

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  pins_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WIDTH-1:0]  rd_data,
   output logic              irq_o
);

   localparam int CTRL_PAD = WIDTH - CTRL_STORED_W;
   localparam int STAT_PAD = WIDTH - 3;

   logic [WIDTH-1:0] rise_mask, fall_mask, rise_vec, fall_vec;
   ctrl_t            ctrl;
   logic             clr_pulse, rise_flag, fall_flag;

   edge_regs #(.WIDTH(WIDTH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rise_mask (rise_mask),
      .fall_mask (fall_mask),
      .ctrl      (ctrl),
      .clr_pulse (clr_pulse)
   );

   edge_sampler #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_i    (pins_i),
      .sync_mode (ctrl.sync_mode),
      .rise_vec  (rise_vec),
      .fall_vec  (fall_vec)
   );

   edge_flag u_rise_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (|(rise_vec & rise_mask)),
      .clr   (clr_pulse),
      .flag  (rise_flag)
   );

   edge_flag u_fall_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (|(fall_vec & fall_mask)),
      .clr   (clr_pulse),
      .flag  (fall_flag)
   );

   assign irq_o = ctrl.master_en &
                  ((rise_flag & ctrl.rise_ie) | (fall_flag & ctrl.fall_ie));

   always_comb begin
      case (rd_addr)
         ADR_RISE_MASK: rd_data = rise_mask;
         ADR_FALL_MASK: rd_data = fall_mask;
         ADR_CTRL:      rd_data = {{CTRL_PAD{1'b0}}, ctrl};
         default:       rd_data = {{STAT_PAD{1'b0}}, irq_o, fall_flag, rise_flag};
      endcase
   end

   // R6
   ctrl_strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADR_CTRL) |-> !rd_data[CTRL_CLR_BIT]);

endmodule

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pins_i = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       irq_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   edge_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_o(irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         errors = errors + 1;
         $display("FAIL watchdog R1 actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // fields: rise mask, fall mask, ctrl, pins before, pins after, {irq, fall, rise}
   localparam int NVEC = 7;
   localparam logic [42:0] VEC [NVEC] = '{
      {8'h01, 8'h00, 8'h03, 8'h00, 8'h01, 3'b101},  // R3 direct rise
      {8'h80, 8'h80, 8'h07, 8'h80, 8'h00, 3'b110},  // R4 direct fall
      {8'h0F, 8'hF0, 8'h0B, 8'hF0, 8'h0F, 3'b111},  // R3 R4 synced both
      {8'hF0, 8'h0F, 8'h0F, 8'hF0, 8'h0F, 3'b000},  // R3 R4 masked off
      {8'hFF, 8'hFF, 8'h06, 8'h00, 8'hAA, 3'b001},  // R9 master off
      {8'hFF, 8'h00, 8'h0D, 8'h00, 8'hFF, 3'b001},  // R8 rise flag, only fall ie
      {8'h00, 8'h01, 8'h05, 8'h01, 8'h00, 3'b110}   // R8 fall irq
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check("R1 reset read", v, 8'h00);
      end
      check("R1 reset irq", {7'b0, irq_o}, 8'h00);

      // R2 mask readback
      wr(2'd0, 8'h5A); wr(2'd1, 8'hC3);
      rd(2'd0, v); check("R2 rise mask", v, 8'h5A);
      rd(2'd1, v); check("R2 fall mask", v, 8'hC3);

      // R6 strobe bit reads 0
      wr(2'd2, 8'h1F);
      rd(2'd2, v); check("R6 ctrl readback", v, 8'h0F);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         wr(2'd0, VEC[i][42:35]);
         wr(2'd1, VEC[i][34:27]);
         @(negedge clk) pins_i = VEC[i][18:11];
         idle(5);
         wr(2'd2, VEC[i][26:19] | 8'h10);
         @(negedge clk) pins_i = VEC[i][10:3];
         idle(5);
         rd(2'd3, v);
         check($sformatf("R3 R4 R8 R9 vec%0d status", i), v, {5'b0, VEC[i][2:0]});
         check($sformatf("R8 R9 vec%0d irq", i), {7'b0, irq_o}, {7'b0, VEC[i][2]});
      end

      // R5 sticky: fall flag from last vector survives further input activity
      @(negedge clk) pins_i = 8'h01;
      idle(4);
      @(negedge clk) pins_i = 8'h00;
      idle(10);
      rd(2'd3, v); check("R5 sticky", v, 8'h06);

      // R6 clear
      wr(2'd2, 8'h15);
      rd(2'd3, v); check("R6 clear", v, 8'h00);

      // R7 edge coincident with clear
      wr(2'd0, 8'h01); wr(2'd1, 8'h00);
      wr(2'd2, 8'h03);
      idle(3);
      @(negedge clk);
      pins_i = 8'h01; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h13;
      @(negedge clk);
      wr_en = 1'b0;
      rd(2'd3, v); check("R7 edge beats clear", v, 8'h05);

      // R10 direct mode latency
      @(negedge clk) pins_i = 8'h00;
      idle(5);
      wr(2'd2, 8'h13);
      rd_addr = 2'd3;
      @(negedge clk) pins_i = 8'h01;
      @(negedge clk); #1 check("R10 direct 1 edge", rd_data, 8'h05);

      // R10 synchronized mode latency
      @(negedge clk) pins_i = 8'h00;
      wr(2'd2, 8'h0B);
      idle(6);
      wr(2'd2, 8'h1B);
      rd_addr = 2'd3;
      @(negedge clk) pins_i = 8'h01;
      @(negedge clk); #1 check("R10 sync 1 edge", rd_data, 8'h00);
      @(negedge clk); #1 check("R10 sync 2 edges", rd_data, 8'h00);
      @(negedge clk); #1 check("R10 sync 3 edges", rd_data, 8'h05);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule